// File: doc/BRIEF.md
# FIFO Loopback, Capture and Burst Engine

This block sits between an inbound data FIFO, an outbound data FIFO and a dual-port block RAM that it holds inside. Three control bits, taken from a wider control word, choose how words move. In loopback mode every word taken from the inbound FIFO goes straight out to the outbound FIFO. In capture mode inbound words are stored in the RAM at consecutive addresses. A burst command sends the whole RAM, in address order, to the outbound FIFO.

Both FIFOs are external. The inbound FIFO is first-word-fall-through: its data is valid whenever its empty flag is low, and a read strobe pops that word at the next clock edge. The outbound FIFO accepts the presented word at the edge on which the write strobe is high. The RAM write port is also driven out on ports so that it can be observed. A build parameter chooses where the three control bits sit in the control word. They can be high bits that are always live. They can also be low bits that only act when a bank field in the word holds its all-ones code.

Top module: `fifo_dma_engine`

## Requirements
- R1: With loopback on (control bit 16 when MAP_LOW=0) and no burst running, each inbound word is written to the outbound FIFO in arrival order, in the same cycle in which it is read.
- R2: In capture mode (bit 17), each inbound word is written to the RAM. The first write after capture takes effect goes to address 0, each later write goes to the next address, and the address wraps from depth-1 back to 0.
- R3: When loopback and capture are both on, words are looped and no RAM write occurs.
- R4: The inbound read strobe is never high while the inbound empty flag is high. The outbound write strobe is never high while the outbound full flag is high.
- R5: A low-to-high change of the burst bit (bit 18) while idle starts a burst. A burst writes RAM addresses 0 up to depth-1, in order and exactly once each, to the outbound FIFO and then returns to idle. Holding the bit high does not start another burst.
- R6: An outbound stall during a burst neither skips nor repeats a word, and the presented word stays stable while the stall lasts.
- R7: `busy` rises in the cycle after a burst is started and stays high until the last burst word has been accepted.
- R8: While a burst is running, and in the cycle that starts it, the inbound FIFO is not read. Any pending loopback traffic resumes after the burst.
- R9: With MAP_LOW=1, the loopback, capture and burst bits are bits 4, 5 and 6. They act only when bits [2:0] equal 3'b111.
- R10: Out of reset, with no control bit set, no strobe is active and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | CTRL_W | Control word carrying the mode bits |
| ififo_empty | input | 1 | Inbound FIFO empty flag |
| ififo_data | input | DATA_W | Inbound FIFO head word |
| ififo_rd | output | 1 | Inbound FIFO pop strobe |
| ofifo_full | input | 1 | Outbound FIFO full flag |
| ofifo_wr | output | 1 | Outbound FIFO push strobe |
| ofifo_data | output | DATA_W | Word pushed to the outbound FIFO |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | RAM_AW | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| busy | output | 1 | Burst in progress |

## Verification
A capture address counter that was not cleared on entry shows up as a write to a non-zero address on the first captured word. A wrong wrap shows up on word depth+1. A burst head pointer that drifts during a stall shows up on the next accepted outbound word as a repeated or missing RAM entry, which is visible as soon as the stall ends. A busy flag that stays set too long blocks the inbound FIFO, so pending loopback words never appear. A busy flag that drops too early cuts the outbound word count short of the RAM depth.

// File: rtl/fde_pkg.sv
package fde_pkg;
  typedef struct packed {
    logic loop_on;
    logic cap_on;
    logic burst_req;
  } fde_mode_t;
endpackage

// File: rtl/fde_ctrl_decode.sv
module fde_ctrl_decode
  import fde_pkg::*;
#(
  parameter int CTRL_W  = 32,
  parameter int MAP_LOW = 0,
  parameter int BANK_W  = 3
) (
  input  logic [CTRL_W-1:0] ctrl_word,
  output fde_mode_t         mode
);
  logic unused_ctrl;
  assign unused_ctrl = ^ctrl_word;

  generate
    if (MAP_LOW != 0) begin : g_low
      logic bank_hit;
      assign bank_hit       = (ctrl_word[BANK_W-1:0] == {BANK_W{1'b1}});
      assign mode.loop_on   = bank_hit & ctrl_word[4];
      assign mode.cap_on    = bank_hit & ctrl_word[5];
      assign mode.burst_req = bank_hit & ctrl_word[6];
    end else begin : g_high
      assign mode.loop_on   = ctrl_word[16];
      assign mode.cap_on    = ctrl_word[17];
      assign mode.burst_req = ctrl_word[18];
    end
  endgenerate
endmodule

// File: rtl/fde_cap_addr.sv
module fde_cap_addr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          wr,
  output logic          entering,
  output logic [AW-1:0] addr
);
  logic          act_q;
  logic [AW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  assign entering = active & ~act_q;
  assign addr     = entering ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt   <= '0;
    end else begin
      act_q <= active;
      if (wr)            cnt <= bump(addr);
      else if (entering) cnt <= '0;
    end
  end
endmodule

// File: rtl/fde_burst_ctrl.sv
module fde_burst_ctrl #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trigger,
  input  logic          out_full,
  output logic          busy,
  output logic          start,
  output logic          adv,
  output logic [AW-1:0] head,
  output logic [AW-1:0] rd_addr
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic trig_q;
  logic last_adv;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  assign start    = trigger & ~trig_q & ~busy;
  assign adv      = busy & ~out_full;
  assign last_adv = adv & (head == LAST);
  // Look-ahead read address: the RAM output always holds the word at head.
  assign rd_addr  = start ? '0 : (adv ? bump(head) : head);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      busy   <= 1'b0;
      head   <= '0;
    end else begin
      trig_q <= trigger;
      if (start) begin
        busy <= 1'b1;
        head <= '0;
      end else if (adv) begin
        head <= bump(head);
        if (last_adv) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fde_dpram.sv
module fde_dpram #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_dma_engine.sv
module fifo_dma_engine
  import fde_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RAM_AW  = 6,
  parameter int CTRL_W  = 32,
  parameter int MAP_LOW = 0,
  parameter int BANK_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              ififo_empty,
  input  logic [DATA_W-1:0] ififo_data,
  output logic              ififo_rd,
  input  logic              ofifo_full,
  output logic              ofifo_wr,
  output logic [DATA_W-1:0] ofifo_data,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              busy
);
  fde_mode_t         mode;
  logic              cap_active;
  logic              cap_entering;
  logic              burst_start;
  logic              burst_adv;
  logic              in_block;
  logic              loop_go;
  logic [RAM_AW-1:0] burst_head;
  logic [RAM_AW-1:0] rd_addr;
  logic [DATA_W-1:0] ram_q;

  fde_ctrl_decode #(.CTRL_W(CTRL_W), .MAP_LOW(MAP_LOW), .BANK_W(BANK_W)) u_dec (
    .ctrl_word (ctrl_word),
    .mode      (mode)
  );

  // Loopback wins over capture.
  assign cap_active = mode.cap_on & ~mode.loop_on;
  assign in_block   = busy | burst_start;
  assign loop_go    = mode.loop_on & ~in_block & ~ififo_empty & ~ofifo_full;
  assign ram_we     = cap_active & ~in_block & ~ififo_empty;
  assign ififo_rd   = loop_go | ram_we;
  assign ram_wdata  = ififo_data;
  assign ofifo_wr   = busy ? burst_adv : loop_go;
  assign ofifo_data = busy ? ram_q : ififo_data;

  fde_cap_addr #(.AW(RAM_AW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (cap_active),
    .wr       (ram_we),
    .entering (cap_entering),
    .addr     (ram_waddr)
  );

  fde_burst_ctrl #(.AW(RAM_AW)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .trigger  (mode.burst_req),
    .out_full (ofifo_full),
    .busy     (busy),
    .start    (burst_start),
    .adv      (burst_adv),
    .head     (burst_head),
    .rd_addr  (rd_addr)
  );

  fde_dpram #(.DW(DATA_W), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (rd_addr),
    .rdata (ram_q)
  );
endmodule

// File: rtl/fde_checker.sv
module fde_checker #(
  parameter int DATA_W = 32,
  parameter int AW     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ififo_empty,
  input logic              ififo_rd,
  input logic              ofifo_full,
  input logic              ofifo_wr,
  input logic [DATA_W-1:0] ofifo_data,
  input logic              ram_we,
  input logic [AW-1:0]     ram_waddr,
  input logic              busy,
  input logic              burst_start,
  input logic [AW-1:0]     burst_head
);
  localparam logic [AW-1:0] ONE = 1;
  logic past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_IN_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ififo_rd |-> !ififo_empty); // R4
  AST_OUT_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ofifo_wr |-> !ofifo_full); // R4
  AST_LOOP_OVER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !ofifo_wr); // R3
  AST_CAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ram_we && $past(ram_we)) |-> (ram_waddr - $past(ram_waddr)) == ONE); // R2
  AST_BURST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (busy && burst_head == '0)); // R5
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && busy && $past(busy && ofifo_wr)) |-> (burst_head - $past(burst_head)) == ONE); // R6
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && busy && $past(busy && ofifo_full)) |-> $stable(ofifo_data)); // R6
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> busy); // R7
  AST_NO_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || burst_start) |-> !ififo_rd); // R8
endmodule

bind fifo_dma_engine fde_checker #(.DATA_W(DATA_W), .AW(RAM_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ififo_empty (ififo_empty),
  .ififo_rd    (ififo_rd),
  .ofifo_full  (ofifo_full),
  .ofifo_wr    (ofifo_wr),
  .ofifo_data  (ofifo_data),
  .ram_we      (ram_we),
  .ram_waddr   (ram_waddr),
  .busy        (busy),
  .burst_start (burst_start),
  .burst_head  (burst_head)
);

// File: tb/tb_fifo_dma_engine.sv
module tb_fifo_dma_engine;
  localparam int CLK_P = 10;
  localparam int DW    = 32;
  localparam int AW    = 6;
  localparam int D     = 1 << AW;
  localparam logic [31:0] LOOP  = 32'h0001_0000;
  localparam logic [31:0] CAP   = 32'h0002_0000;
  localparam logic [31:0] BURST = 32'h0004_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic ififo_empty = 1'b1;
  logic [DW-1:0] ififo_data = '0;
  logic ofifo_full = 1'b0;
  logic ififo_rd, ofifo_wr, ram_we, busy;
  logic [DW-1:0] ofifo_data, ram_wdata;
  logic [AW-1:0] ram_waddr;
  logic b_rd, b_wr, b_we, b_busy;
  logic [DW-1:0] b_odata, b_wdata;
  logic [AW-1:0] b_waddr;

  always #(CLK_P/2) clk = ~clk;

  fifo_dma_engine #(.DATA_W(DW), .RAM_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .ififo_empty(ififo_empty), .ififo_data(ififo_data), .ififo_rd(ififo_rd),
    .ofifo_full(ofifo_full), .ofifo_wr(ofifo_wr), .ofifo_data(ofifo_data),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .busy(busy));

  fifo_dma_engine #(.DATA_W(DW), .RAM_AW(AW), .MAP_LOW(1)) dut_b (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .ififo_empty(ififo_empty), .ififo_data(ififo_data), .ififo_rd(b_rd),
    .ofifo_full(ofifo_full), .ofifo_wr(b_wr), .ofifo_data(b_odata),
    .ram_we(b_we), .ram_waddr(b_waddr), .ram_wdata(b_wdata), .busy(b_busy));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int in_hd = 0, in_tl = 0, out_n = 0, n_we = 0;
  int viol_flow = 0, viol_busy = 0, wa_err = 0;
  logic [DW-1:0] in_q [512];
  logic [DW-1:0] out_q [512];
  logic [DW-1:0] shadow [D];
  logic [AW-1:0] exp_wa = '0;
  logic [31:0] ctrl_next = '0;
  logic stall = 1'b0;
  logic busy_s = 1'b0;
  logic done = 1'b0;

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] w);
    in_q[in_tl] = w;
    in_tl++;
  endtask

  // One clock: drive at the falling edge, sample just before the rising edge.
  task automatic step();
    @(negedge clk);
    ctrl_word   = ctrl_next;
    ififo_empty = (in_hd == in_tl);
    ififo_data  = in_q[in_hd];
    ofifo_full  = stall && (cyc % 3 == 2);
    #(CLK_P/2 - 1);
    if (ififo_rd && ififo_empty) viol_flow++;
    if (ofifo_wr && ofifo_full)  viol_flow++;
    if (busy && ififo_rd)        viol_busy++;
    if (ififo_rd) in_hd++;
    if (ofifo_wr) begin
      out_q[out_n] = ofifo_data;
      out_n++;
    end
    if (ram_we) begin
      n_we++;
      shadow[ram_waddr] = ram_wdata;
      if (ram_waddr != exp_wa) wa_err++;
      exp_wa = exp_wa + 1'b1;
    end
    busy_s = busy;
  endtask

  task automatic run_until_out(input int target, input int limit);
    for (int i = 0; i < limit && out_n < target; i++) step();
  endtask

  task automatic run_until_in_empty(input int limit);
    for (int i = 0; i < limit && in_hd != in_tl; i++) step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    check(!ififo_rd && !ofifo_wr && !ram_we && !busy, "R10 idle after reset",
          {ififo_rd, ofifo_wr, ram_we, busy}, 0);
  endtask

  task automatic t_map_low();
    @(negedge clk);
    ififo_empty = 1'b0; ififo_data = 32'hA5A5_0001; ofifo_full = 1'b0;
    ctrl_word = 32'h0000_0017;
    #1;
    check(b_rd && b_wr && !ififo_rd, "R9 low loop bit with bank 111", {b_rd, b_wr, ififo_rd}, 3'b110);
    ctrl_word = 32'h0000_0016;
    #1;
    check(!b_rd && !b_wr, "R9 bank 110 ignored", {b_rd, b_wr}, 0);
    ctrl_word = 32'h0000_0027;
    #1;
    check(b_we && !b_wr, "R9 low capture bit", {b_we, b_wr}, 2'b10);
    ctrl_word = 32'h0001_0007;
    #1;
    check(!b_rd && ififo_rd, "R9 high bit ignored in low map", {b_rd, ififo_rd}, 2'b01);
    @(negedge clk);
    ctrl_word = 32'h0000_0047; ififo_empty = 1'b1;
    @(negedge clk);
    #1;
    check(b_busy && !busy, "R9 low burst bit", {b_busy, busy}, 2'b10);
    ctrl_word = '0;
    ctrl_next = '0;
  endtask

  task automatic t_loop();
    int base = out_n, bad = 0, we0 = n_we;
    for (int i = 0; i < 10; i++) push(32'h1000_0000 + i);
    stall = 1'b1; ctrl_next = LOOP;
    run_until_out(base + 10, 200);
    for (int i = 0; i < 10; i++) if (out_q[base + i] != 32'h1000_0000 + i) bad++;
    check(out_n == base + 10, "R1 loop word count", out_n - base, 10);
    check(bad == 0, "R1 loop order", bad, 0);
    check(n_we == we0, "R1 no RAM write in loopback", n_we - we0, 0);
  endtask

  task automatic t_priority();
    int base = out_n, we0 = n_we, bad = 0;
    for (int i = 0; i < 6; i++) push(32'h2000_0000 + i);
    ctrl_next = LOOP | CAP;
    run_until_out(base + 6, 200);
    for (int i = 0; i < 6; i++) if (out_q[base + i] != 32'h2000_0000 + i) bad++;
    check(n_we == we0 && bad == 0 && out_n == base + 6, "R3 loop wins over capture",
          n_we - we0, 0);
  endtask

  task automatic t_capture();
    int out0;
    ctrl_next = '0; step(); step();
    out0 = out_n;
    exp_wa = '0; wa_err = 0;
    for (int i = 0; i < 5; i++) push(32'h3000_0000 + i);
    ctrl_next = CAP;
    run_until_in_empty(100);
    ctrl_next = '0; step(); step();
    exp_wa = '0;
    for (int i = 0; i < 3; i++) push(32'h3100_0000 + i);
    ctrl_next = CAP;
    run_until_in_empty(100);
    check(wa_err == 0 && exp_wa == 3, "R2 re-entry restarts at 0", wa_err, 0);
    for (int i = 0; i < D + 2; i++) push(32'h3200_0000 + i);
    run_until_in_empty(400);
    check(wa_err == 0, "R2 consecutive addresses with wrap", wa_err, 0);
    check(shadow[0] == 32'h3200_0000 + D - 3 && shadow[1] == 32'h3200_0000 + D - 2,
          "R2 wrap overwrote address 0", shadow[0], 32'h3200_0000 + D - 3);
    check(out_n == out0, "R2 capture writes no outbound word", out_n - out0, 0);
  endtask

  task automatic t_burst();
    int base, bad = 0, rd0;
    logic [DW-1:0] img [D];
    for (int i = 0; i < D; i++) img[i] = shadow[i];
    ctrl_next = '0; step();
    base = out_n;
    for (int i = 0; i < 4; i++) push(32'h4000_0000 + i);
    stall = 1'b1;
    viol_busy = 0;
    ctrl_next = LOOP | BURST;
    rd0 = in_hd;
    step();
    check(in_hd == rd0, "R8 no read on start cycle", in_hd - rd0, 0);
    step();
    check(busy_s == 1'b1, "R7 busy after start", busy_s, 1);
    run_until_out(base + D + 4, 1000);
    for (int i = 0; i < D; i++) if (out_q[base + i] != img[i]) bad++;
    check(bad == 0, "R5 R6 burst order under stalls", bad, 0);
    for (int i = 0; i < 4; i++) if (out_q[base + D + i] != 32'h4000_0000 + i) bad++;
    check(bad == 0 && out_n == base + D + 4, "R8 loop resumes after burst", out_n - base, D + 4);
    check(viol_busy == 0, "R8 no inbound read while busy", viol_busy, 0);
    step();
    check(busy_s == 1'b0, "R7 busy low after burst", busy_s, 0);
    for (int i = 0; i < 20; i++) step();
    check(out_n == base + D + 4, "R5 held bit no retrigger", out_n - base, D + 4);
    ctrl_next = '0; step();
    stall = 1'b0;
    ctrl_next = BURST;
    base = out_n;
    run_until_out(base + D, 400);
    for (int i = 0; i < 10; i++) step();
    check(out_n == base + D, "R5 new edge gives exactly one burst", out_n - base, D);
    check(viol_flow == 0, "R4 flow control respected", viol_flow, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map_low();
    ctrl_next = '0; step(); step();
    t_loop();
    t_priority();
    t_capture();
    t_burst();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule